// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the register file of a RISC integer core whose procedures each see 32 architectural registers. Numbers 0 to 7 are global and are the same in every procedure. Numbers 8 to 31 come from a 24-register window that slides over a larger stack of physical registers. A call (save) moves the window 16 registers down the stack, and a return (restore) moves it back up. So the outgoing registers 8..15 of a caller become the incoming registers 24..31 of its callee, and the middle eight, 16..23, stay private to each procedure. Register 0 always reads as zero.

The file has two combinational read ports and one write port, each addressed by a 5-bit architectural number. A shared translator turns each number into a physical index. Globals sit at physical 0..7. Windowed register n in window w sits at 8 + ((16*w + n - 8) mod 16*NWIN). The current window pointer (cwp) starts at NWIN-1. Window 0 is held invalid, so the deepest usable window is 1. A small state machine tracks where the pointer stands. Bottom means cwp = NWIN-1. Inner means a window strictly between the ends. Top means cwp = 1. The transitions are as follows:
- Bottom goes to Inner on a save, or to Top on a save when NWIN = 3.
- Inner goes to Top on a save that lands on window 1, and stays Inner on other saves.
- Inner goes to Bottom on a restore that lands on window NWIN-1, and stays Inner on other restores.
- Top goes back to Inner or Bottom on a restore.
- A save in Top and a restore in Bottom are refused: the pointer holds and a flag rises.

Spilling and filling windows to memory are left to trap software outside the block. NWIN ranges from 3 to 32.

Top module: `winreg_file`

## Requirements
- R1: After reset, cwp equals NWIN-1 (binary), every register reads zero, and both overflow and underflow are low.
- R2: Architectural register 0 always reads zero on both ports, even in the cycle it is written, and writes to it are discarded.
- R3: Registers 1..7 are shared by all windows: a value written in one window reads back unchanged in any other window.
- R4: A save alone decrements cwp by one at the next clock edge, and a restore alone increments it. In both cases the two flags stay low while the move is allowed.
- R5: After a save, the callee's registers 24..31 read what the caller held in 8..15. After a restore, the caller's registers 8..15 read what the callee wrote to 24..31.
- R6: Registers 16..23 are private to each window: a value written there is not seen in the adjacent window.
- R7: A save while cwp = 1 drives overflow high in the same cycle, and cwp stays unchanged.
- R8: A restore while cwp = NWIN-1 drives underflow high in the same cycle, and cwp stays unchanged.
- R9: A write issued in the same cycle as a save or restore lands in the window in effect before the move.
- R10: A read of the register being written in the same cycle returns the new write data (write-first).
- R11: A save and a restore in the same cycle leave cwp unchanged and raise neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Architectural number for read port A |
| rd_a_data | output | XLEN | Read port A data (combinational) |
| rd_b_idx | input | 5 | Architectural number for read port B |
| rd_b_data | output | XLEN | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move window down (call) |
| restore_req | input | 1 | Move window up (return) |
| cwp | output | $clog2(NWIN) | Current window pointer |
| overflow | output | 1 | Save refused at the deepest window |
| underflow | output | 1 | Restore refused at the bottom window |

## Verification
A register write and a window move can fall in the same cycle. The bench provokes this by writing register 24 together with a restore. It then reads register 8 in the restored window, and the new data must appear there because the write used the pre-move window. A save and a restore are also issued together, and a move is requested exactly at each end of the stack. In each case the pointer is judged one cycle later, and the flags are judged in the request cycle itself.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    localparam int GLOBALS  = 8;
    localparam int WIN_STEP = 16;
    localparam int ARCH_W   = 5;

    typedef enum logic [1:0] {
        WS_BOTTOM = 2'd0,
        WS_INNER  = 2'd1,
        WS_TOP    = 2'd2
    } win_state_e;

    typedef enum logic [1:0] {
        MV_NONE    = 2'd0,
        MV_SAVE    = 2'd1,
        MV_RESTORE = 2'd2
    } win_move_e;
endpackage

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WPW  = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           save_req,
    input  logic           restore_req,
    output logic [WPW-1:0] cwp,
    output logic           overflow,
    output logic           underflow
);
    localparam logic [WPW-1:0] CWP_HOME  = WPW'(NWIN - 1);
    localparam logic [WPW-1:0] CWP_LIMIT = WPW'(1);

    function automatic logic [WPW-1:0] wrap_dec(input logic [WPW-1:0] x);
        return (x == '0) ? CWP_HOME : x - WPW'(1);
    endfunction

    function automatic logic [WPW-1:0] wrap_inc(input logic [WPW-1:0] x);
        return (x == CWP_HOME) ? '0 : x + WPW'(1);
    endfunction

    win_state_e     state_q, state_nx;
    logic [WPW-1:0] cwp_q, cwp_nx;
    win_move_e      move;
    logic [WPW-1:0] cwp_down, cwp_up;

    always_comb begin
        if (save_req && !restore_req)
            move = MV_SAVE;
        else if (restore_req && !save_req)
            move = MV_RESTORE;
        else
            move = MV_NONE;
        cwp_down = wrap_dec(cwp_q);
        cwp_up   = wrap_inc(cwp_q);
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        cwp_nx   = cwp_q;
        unique case (state_q)
            WS_BOTTOM: begin
                if (move == MV_SAVE) begin
                    cwp_nx   = cwp_down;
                    state_nx = (cwp_down == CWP_LIMIT) ? WS_TOP : WS_INNER;
                end
            end
            WS_INNER: begin
                if (move == MV_SAVE) begin
                    cwp_nx   = cwp_down;
                    state_nx = (cwp_down == CWP_LIMIT) ? WS_TOP : WS_INNER;
                end else if (move == MV_RESTORE) begin
                    cwp_nx   = cwp_up;
                    state_nx = (cwp_up == CWP_HOME) ? WS_BOTTOM : WS_INNER;
                end
            end
            WS_TOP: begin
                if (move == MV_RESTORE) begin
                    cwp_nx   = cwp_up;
                    state_nx = (cwp_up == CWP_HOME) ? WS_BOTTOM : WS_INNER;
                end
            end
            default: begin
                state_nx = WS_BOTTOM;
                cwp_nx   = CWP_HOME;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_BOTTOM;
            cwp_q   <= CWP_HOME;
        end else begin
            state_q <= state_nx;
            cwp_q   <= cwp_nx;
        end
    end

    // Outputs
    always_comb begin
        cwp       = cwp_q;
        overflow  = (state_q == WS_TOP)    && (move == MV_SAVE);
        underflow = (state_q == WS_BOTTOM) && (move == MV_RESTORE);
    end

    p_save_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && !overflow) |=> (cwp == wrap_dec($past(cwp))));
    p_restore_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !underflow) |=> (cwp == wrap_inc($past(cwp))));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> $stable(cwp));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> $stable(cwp));
    p_both_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> $stable(cwp));
    p_never_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cwp != '0);
    p_flags_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));
endmodule

// File: rtl/winreg_map.sv
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WPW  = $clog2(NWIN),
    parameter int PW   = $clog2(GLOBALS + WIN_STEP * NWIN)
) (
    input  logic [WPW-1:0]    cwp,
    input  logic [ARCH_W-1:0] arch,
    output logic [PW-1:0]     phys
);
    localparam int            NPHYS = GLOBALS + WIN_STEP * NWIN;
    localparam logic [PW:0]   WSZ   = (PW+1)'(WIN_STEP * NWIN);

    logic [PW:0] raw, wrapped;

    always_comb begin
        raw     = (PW+1)'(cwp) * (PW+1)'(WIN_STEP) + (PW+1)'(arch) - (PW+1)'(GLOBALS);
        wrapped = (raw >= WSZ) ? raw - WSZ : raw;
        if (arch < ARCH_W'(GLOBALS))
            phys = PW'(arch);
        else
            phys = PW'(wrapped + (PW+1)'(GLOBALS));
    end

    always_comb begin
        a_phys_range_r5: assert (int'(phys) < NPHYS);
    end
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int XLEN  = 32,
    parameter int NPHYS = 136,
    parameter int PW    = $clog2(NPHYS),
    parameter int NRD   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [PW-1:0]   wphys,
    input  logic [XLEN-1:0] wdata,
    input  logic [PW-1:0]   rphys [NRD],
    output logic [XLEN-1:0] rdata [NRD]
);
    logic [XLEN-1:0] mem [NPHYS];
    logic            wr_live;

    assign wr_live = we && (wphys != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                mem[i] <= '0;
        end else if (wr_live) begin
            mem[wphys] <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            always_comb begin
                if (rphys[g] == '0)
                    rdata[g] = '0;
                else if (wr_live && (wphys == rphys[g]))
                    rdata[g] = wdata;
                else
                    rdata[g] = mem[rphys[g]];
            end
        end
    endgenerate

    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> (mem[$past(wphys)] == $past(wdata)));
    p_zero_cell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0);
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [4:0]                rd_a_idx,
    output logic [XLEN-1:0]           rd_a_data,
    input  logic [4:0]                rd_b_idx,
    output logic [XLEN-1:0]           rd_b_data,
    input  logic                      wr_en,
    input  logic [4:0]                wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic                      save_req,
    input  logic                      restore_req,
    output logic [$clog2(NWIN)-1:0]   cwp,
    output logic                      overflow,
    output logic                      underflow
);
    localparam int WPW    = $clog2(NWIN);
    localparam int NPHYS  = GLOBALS + WIN_STEP * NWIN;
    localparam int PW     = $clog2(NPHYS);
    localparam int NRD    = 2;
    localparam int NPORTS = NRD + 1;

    logic [WPW-1:0]    cwp_w;
    logic [ARCH_W-1:0] arch [NPORTS];
    logic [PW-1:0]     phys [NPORTS];
    logic [PW-1:0]     rphys [NRD];
    logic [XLEN-1:0]   rdata [NRD];

    winreg_ctrl #(.NWIN(NWIN), .WPW(WPW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cwp         (cwp_w),
        .overflow    (overflow),
        .underflow   (underflow)
    );

    assign arch[0] = rd_a_idx;
    assign arch[1] = rd_b_idx;
    assign arch[2] = wr_idx;

    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_map
            winreg_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_map (
                .cwp  (cwp_w),
                .arch (arch[g]),
                .phys (phys[g])
            );
        end
        for (genvar r = 0; r < NRD; r++) begin : g_rsel
            assign rphys[r] = phys[r];
        end
    endgenerate

    winreg_store #(.XLEN(XLEN), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wphys (phys[NRD]),
        .wdata (wr_data),
        .rphys (rphys),
        .rdata (rdata)
    );

    assign rd_a_data = rdata[0];
    assign rd_b_data = rdata[1];
    assign cwp       = cwp_w;

    p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
    p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
    p_global_across_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((save_req || restore_req) && !wr_en && (rd_a_idx < 5'd8) && (rd_a_idx != 5'd0))
        |=> ((rd_a_idx != $past(rd_a_idx)) || wr_en || (rd_a_data == $past(rd_a_data))));
endmodule

// File: tb/tb_winreg_file.sv
module tb_winreg_file;
    localparam int NWIN = 8;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [4:0]      rd_a_idx, rd_b_idx, wr_idx;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data;
    logic            wr_en, save_req, restore_req;
    logic [2:0]      cwp;
    logic            overflow, underflow;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    winreg_file #(.NWIN(NWIN), .XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .cwp(cwp), .overflow(overflow), .underflow(underflow)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  widx;
        logic [31:0] wdat;
        logic        sv;
        logic        rs;
        logic [4:0]  ridx;
        logic [31:0] exp;
        logic [2:0]  ecwp;
        logic [3:0]  req;
    } vec_t;

    // Each row: inputs for one cycle; read and cwp checked before the edge.
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd1,  32'h11, 1'b0, 1'b0, 5'd1,  32'h11, 3'd7, 4'd10}, // R10 bypass
        '{1'b1, 5'd8,  32'hA8, 1'b0, 1'b0, 5'd1,  32'h11, 3'd7, 4'd3},
        '{1'b1, 5'd16, 32'h16, 1'b0, 1'b0, 5'd8,  32'hA8, 3'd7, 4'd5},
        '{1'b0, 5'd0,  32'h0,  1'b1, 1'b0, 5'd16, 32'h16, 3'd7, 4'd6},
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd24, 32'hA8, 3'd6, 4'd5},  // R5 ins=outs
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd16, 32'h0,  3'd6, 4'd6},  // R6 private
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd1,  32'h11, 3'd6, 4'd3},  // R3 global
        '{1'b1, 5'd24, 32'hB4, 1'b0, 1'b1, 5'd24, 32'hB4, 3'd6, 4'd9},  // R9 write+restore
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd8,  32'hB4, 3'd7, 4'd9},  // R9 landed pre-move
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd16, 32'h16, 3'd7, 4'd6},
        '{1'b1, 5'd0,  32'hFF, 1'b0, 1'b0, 5'd0,  32'h0,  3'd7, 4'd2},  // R2 no bypass on r0
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd0,  32'h0,  3'd7, 4'd2},
        '{1'b0, 5'd0,  32'h0,  1'b1, 1'b1, 5'd8,  32'hB4, 3'd7, 4'd11}, // R11 both
        '{1'b0, 5'd0,  32'h0,  1'b0, 1'b0, 5'd8,  32'hB4, 3'd7, 4'd11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        save_req = 1'b0; restore_req = 1'b0;
        rd_a_idx = '0; rd_b_idx = '0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_a_idx = 5'd9; rd_b_idx = 5'd5;
        #2;
        chk("R1 cwp", 32'(cwp), 32'd7);
        chk("R1 rd_a", rd_a_data, 32'h0);
        chk("R1 rd_b", rd_b_data, 32'h0);
        chk("R1 flags", {30'd0, overflow, underflow}, 32'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_idx = VECS[i].widx; wr_data = VECS[i].wdat;
            save_req = VECS[i].sv; restore_req = VECS[i].rs; rd_a_idx = VECS[i].ridx;
            #2;
            total++;
            if (rd_a_data !== VECS[i].exp || cwp !== VECS[i].ecwp) begin
                bad++;
                $display("FAIL R%0d row %0d actual=%h/%0d expected=%h/%0d",
                         VECS[i].req, i, rd_a_data, cwp, VECS[i].exp, VECS[i].ecwp);
            end
            if (VECS[i].sv && VECS[i].rs)
                chk("R11 flags", {30'd0, overflow, underflow}, 32'd0);
        end

        // Directed: global through port B, then descend to the deepest window
        @(negedge clk);
        idle_inputs();
        wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h55;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            idle_inputs();
            save_req = 1'b1;
            #2;
            chk("R4 no overflow on save", 32'(overflow), 32'd0);
            @(negedge clk);
            save_req = 1'b0;
            #2;
            chk("R4 cwp after save", 32'(cwp), 32'(6 - k));
        end
        rd_b_idx = 5'd5;
        #1;
        chk("R3 global on port B in window 1", rd_b_data, 32'h55);

        // R7: save at window 1
        @(negedge clk);
        save_req = 1'b1;
        #2;
        chk("R7 overflow", 32'(overflow), 32'd1);
        chk("R7 no underflow", 32'(underflow), 32'd0);
        @(negedge clk);
        save_req = 1'b0;
        #2;
        chk("R7 cwp held", 32'(cwp), 32'd1);

        // Climb back up
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            restore_req = 1'b1;
            #2;
            chk("R4 no underflow on restore", 32'(underflow), 32'd0);
            @(negedge clk);
            restore_req = 1'b0;
            #2;
            chk("R4 cwp after restore", 32'(cwp), 32'(2 + k));
        end

        // R8: restore at bottom
        @(negedge clk);
        restore_req = 1'b1;
        #2;
        chk("R8 underflow", 32'(underflow), 32'd1);
        @(negedge clk);
        restore_req = 1'b0;
        #2;
        chk("R8 cwp held", 32'(cwp), 32'd7);

        // R2: r0 stays zero on both ports after writes
        rd_a_idx = 5'd0; rd_b_idx = 5'd0;
        #1;
        chk("R2 rd_a r0", rd_a_data, 32'h0);
        chk("R2 rd_b r0", rd_b_data, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule